// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial slave that holds the control bytes of a system clock generator. A bus master writes or reads a bank of six 8-bit registers over a clock line and an open-drain data line. Both lines are oversampled by the system clock. The block finds start and stop conditions and shifts bytes in on rising serial-clock edges. It answers each byte it accepts by pulling the data line low during the ninth clock.

A write begins with the address byte D2h. The first two bytes after that byte are a command code and a byte count. They are acknowledged and thrown away. Each later byte lands in the next register, starting at register 0. A read begins with D3h. The slave first sends a count byte and then the registers in ascending order, for as long as the master acknowledges.

The register bits leave the block as one flat bus. The fields of register 0 are also decoded onto their own pins. Those pins drive frequency selection, spread-spectrum control and the global output tristate. Registers 1 to 5 act as per-output enable masks.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: After reset, register 0 reads 00h, registers 1 to 5 read FFh, and the data line is released.
- R2: An address byte of D2h (7-bit address 69h, direction bit 0) opens a write. The two bytes after it are acknowledged and change no register.
- R3: The data bytes of a write fill register 0, then 1, and so on, in arrival order. Register n occupies `regFile[8n+7:8n]`.
- R4: Every byte of an addressed transaction that the slave receives is acknowledged: the data line is low while the serial clock is high in the ninth bit slot.
- R5: An address byte other than D2h or D3h is not acknowledged. The bytes that follow it up to the stop condition leave every register unchanged.
- R6: A write byte aimed beyond register 5 is acknowledged and discarded.
- R7: An address byte of D3h opens a read. The slave sends the count byte 06h and then registers 0, 1, 2 and on, most significant bit first.
- R8: A read that runs past register 5 returns FFh.
- R9: When the master does not acknowledge a read byte, the slave stops driving until the next start.
- R10: A stop condition ends any transaction. A write that carries no data bytes leaves every register unchanged.
- R11: The register 0 fields appear on their own pins: frequency code = bits 6:4, serial-select flag = bit 3, down-spread = bit 2, spread enable = bit 1, all-outputs-off = bit 0.
- R12: The slave drives the data line only while acknowledging or sending a 0 read bit. It starts driving only after a falling serial-clock edge.
- R13: A repeated start in the middle of a write begins a new transaction. Registers written before it keep their new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level as seen on the wire |
| sdaDriveLow | output | 1 | 1 pulls the data line low; 0 releases it |
| regFile | output | 48 | All six registers, register n in bits 8n+7:8n |
| freqCode | output | 3 | Frequency code from register 0 |
| freqBySerial | output | 1 | Selects the serial frequency code over the strap pins |
| spreadDown | output | 1 | 1 = down spread, 0 = center spread |
| spreadOn | output | 1 | Spread-spectrum enable |
| outputsOff | output | 1 | Puts all clock outputs in tristate |

## Verification
The checks assume three things about the inputs. The master changes the data line only while the serial clock is low, except for start and stop. Each high and low phase of the serial clock lasts well beyond the two-flop synchronizer delay. The master never raises the data line for a start while the slave is pulling it low. The bench's master model holds every phase for twenty system clocks. It changes the data line right after lowering the clock and issues a start or stop only after the slave has released the line. The same model also samples the line, so acknowledge and read-bit checks use what an external master would see.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_BITS,
    ST_RX_ACK,
    ST_TX_BITS,
    ST_TX_ACK
  } slvState_t;

  typedef enum logic [1:0] {
    MD_ADDR,
    MD_WR,
    MD_RD
  } slvMode_t;

  // synchronized bus events, one system clock wide
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic sdaLvl;
  } busEvt_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              wrStb;
    logic [PTR_W-1:0]  wrIdx;
    logic [BYTE_W-1:0] wrData;
    logic [PTR_W-1:0]  rdIdx;
  } regStb_t;
endpackage

// File: rtl/clkcfg_bus_sense.sv
module clkcfg_bus_sense
  import clkcfg_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  output busEvt_t evt
);
  localparam int TOP = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] sclSync;
  logic [SYNC_DEPTH-1:0] sdaSync;
  logic sclPrev;
  logic sdaPrev;

  // idle bus is high on both lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_DEPTH-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_DEPTH-2:0], sdaIn};
      sclPrev <= sclSync[TOP];
      sdaPrev <= sdaSync[TOP];
    end
  end

  always_comb begin
    evt.sclRise = sclSync[TOP] & ~sclPrev;
    evt.sclFall = ~sclSync[TOP] & sclPrev;
    evt.startEv = sclSync[TOP] & sclPrev & sdaPrev & ~sdaSync[TOP];
    evt.stopEv  = sclSync[TOP] & sclPrev & ~sdaPrev & sdaSync[TOP];
    evt.sdaLvl  = sdaSync[TOP];
  end
endmodule

// File: rtl/clkcfg_slave_ctrl.sv
module clkcfg_slave_ctrl
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h69,
  parameter int         REG_COUNT    = 6,
  parameter int         HEADER_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           evt,
  input  logic [BYTE_W-1:0] rdByte,
  output regStb_t           stb,
  output logic              sdaDriveLow
);
  localparam logic [BYTE_W-1:0] WR_ADDR  = {DEV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] RD_ADDR  = {DEV_ADDR, 1'b1};
  localparam logic [BYTE_W-1:0] CNT_BYTE = BYTE_W'(REG_COUNT);
  localparam logic [PTR_W-1:0]  SKIP_N   = PTR_W'(HEADER_BYTES);
  localparam logic [PTR_W-1:0]  PTR_MAX  = '1;

  slvState_t         state;
  slvMode_t          mode;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] shiftIn;
  logic [BYTE_W-1:0] txShift;
  logic [PTR_W-1:0]  byteIdx;
  logic [PTR_W-1:0]  rdIdx;
  logic              ackIt;
  logic              rdReq;
  logic              mAck;
  logic              sdaOe;
  logic              wrStbQ;
  logic [PTR_W-1:0]  wrIdxQ;
  logic [BYTE_W-1:0] wrDataQ;
  logic [BYTE_W-1:0] rxByte;

  assign rxByte = {shiftIn[BYTE_W-2:0], evt.sdaLvl};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      mode    <= MD_ADDR;
      bitCnt  <= '0;
      shiftIn <= '0;
      txShift <= '1;
      byteIdx <= '0;
      rdIdx   <= '0;
      ackIt   <= 1'b0;
      rdReq   <= 1'b0;
      mAck    <= 1'b0;
      sdaOe   <= 1'b0;
      wrStbQ  <= 1'b0;
      wrIdxQ  <= '0;
      wrDataQ <= '0;
    end else begin
      wrStbQ <= 1'b0;
      if (evt.stopEv) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else if (evt.startEv) begin
        state   <= ST_RX_BITS;
        mode    <= MD_ADDR;
        bitCnt  <= '0;
        byteIdx <= '0;
        rdIdx   <= '0;
        ackIt   <= 1'b0;
        sdaOe   <= 1'b0;
      end else begin
        unique case (state)
          ST_RX_BITS: begin
            if (evt.sclRise && bitCnt < 4'd8) begin
              shiftIn <= rxByte;
              bitCnt  <= bitCnt + 4'd1;
              if (bitCnt == 4'd7) begin
                if (mode == MD_ADDR) begin
                  ackIt <= (rxByte == WR_ADDR) || (rxByte == RD_ADDR);
                  rdReq <= rxByte[0];
                end else begin
                  ackIt <= 1'b1;
                  if (byteIdx >= SKIP_N) begin
                    wrStbQ  <= 1'b1;
                    wrIdxQ  <= byteIdx - SKIP_N;
                    wrDataQ <= rxByte;
                  end
                  if (byteIdx != PTR_MAX) byteIdx <= byteIdx + 1'b1;
                end
              end
            end else if (evt.sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (ackIt) begin
                state <= ST_RX_ACK;
                sdaOe <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_RX_ACK: begin
            if (evt.sclFall) begin
              if (mode == MD_ADDR && rdReq) begin
                mode    <= MD_RD;
                state   <= ST_TX_BITS;
                txShift <= CNT_BYTE;
                sdaOe   <= ~CNT_BYTE[BYTE_W-1];
              end else begin
                mode  <= MD_WR;
                state <= ST_RX_BITS;
                sdaOe <= 1'b0;
              end
            end
          end
          ST_TX_BITS: begin
            if (evt.sclFall) begin
              if (bitCnt == 4'd7) begin
                state  <= ST_TX_ACK;
                bitCnt <= '0;
                sdaOe  <= 1'b0;
              end else begin
                txShift <= {txShift[BYTE_W-2:0], 1'b1};
                sdaOe   <= ~txShift[BYTE_W-2];
                bitCnt  <= bitCnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (evt.sclRise) begin
              mAck <= ~evt.sdaLvl;
            end else if (evt.sclFall) begin
              if (mAck) begin
                state   <= ST_TX_BITS;
                txShift <= rdByte;
                sdaOe   <= ~rdByte[BYTE_W-1];
                if (rdIdx != PTR_MAX) rdIdx <= rdIdx + 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    stb.wrStb  = wrStbQ;
    stb.wrIdx  = wrIdxQ;
    stb.wrData = wrDataQ;
    stb.rdIdx  = rdIdx;
  end

  assign sdaDriveLow = sdaOe;

  // R12: the line is taken low only right after a falling serial clock
  assert_drive_on_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(evt.sclFall));

  // R10: a stop condition releases the line on the next cycle
  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopEv |=> !sdaOe);
endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
  import clkcfg_pkg::*;
#(
  parameter int                REG_COUNT = 6,
  parameter logic [BYTE_W-1:0] RST_FIRST = 8'h00,
  parameter logic [BYTE_W-1:0] RST_REST  = 8'hFF
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  regStb_t                     stb,
  output logic [BYTE_W-1:0]           rdByte,
  output logic [REG_COUNT*BYTE_W-1:0] regFile
);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(REG_COUNT);

  logic [BYTE_W-1:0] regQ [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    localparam logic [BYTE_W-1:0] RST_VAL = (g == 0) ? RST_FIRST : RST_REST;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[g] <= RST_VAL;
      end else if (stb.wrStb && stb.wrIdx == PTR_W'(g)) begin
        regQ[g] <= stb.wrData;
      end
    end
    assign regFile[g*BYTE_W +: BYTE_W] = regQ[g];
  end

  // out-of-range reads return all ones
  always_comb begin
    rdByte = '1;
    for (int i = 0; i < REG_COUNT; i++) begin
      if (stb.rdIdx == PTR_W'(i)) rdByte = regQ[i];
    end
  end

  // R6: a store aimed past the last register changes nothing
  assert_drop_past_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && stb.wrIdx >= LIMIT) |=> $stable(regFile));

  // R5: without a store strobe the bank holds its contents
  assert_hold_without_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrStb |=> $stable(regFile));
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h69,
  parameter int         REG_COUNT    = 6,
  parameter int         HEADER_BYTES = 2,
  parameter int         SYNC_DEPTH   = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaDriveLow,
  output logic [REG_COUNT*BYTE_W-1:0] regFile,
  output logic [2:0]                  freqCode,
  output logic                        freqBySerial,
  output logic                        spreadDown,
  output logic                        spreadOn,
  output logic                        outputsOff
);
  busEvt_t           evt;
  regStb_t           stb;
  logic [BYTE_W-1:0] rdByte;

  clkcfg_bus_sense #(.SYNC_DEPTH(SYNC_DEPTH)) uSense (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclIn),
    .sdaIn (sdaIn),
    .evt   (evt)
  );

  clkcfg_slave_ctrl #(
    .DEV_ADDR    (DEV_ADDR),
    .REG_COUNT   (REG_COUNT),
    .HEADER_BYTES(HEADER_BYTES)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .rdByte     (rdByte),
    .stb        (stb),
    .sdaDriveLow(sdaDriveLow)
  );

  clkcfg_reg_bank #(.REG_COUNT(REG_COUNT)) uBank (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdByte (rdByte),
    .regFile(regFile)
  );

  assign freqCode     = regFile[6:4];
  assign freqBySerial = regFile[3];
  assign spreadDown   = regFile[2];
  assign spreadOn     = regFile[1];
  assign outputsOff   = regFile[0];
endmodule

// File: tb/tb_clkcfg_serial_slave.sv
module tb_clkcfg_serial_slave;
  localparam int Q = 20;
  localparam logic [7:0] WA = 8'hD2;
  localparam logic [7:0] RA = 8'hD3;
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'h7F, 8'h41, 8'h2A, 8'h15, 8'hF0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLvl = 1'b1;
  logic mLow = 1'b0;
  logic sdaLine;
  logic sdaDriveLow;
  logic [47:0] regFile;
  logic [2:0] freqCode;
  logic freqBySerial, spreadDown, spreadOn, outputsOff;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  assign sdaLine = ~(mLow | sdaDriveLow);

  clkcfg_serial_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLvl), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .regFile(regFile), .freqCode(freqCode),
    .freqBySerial(freqBySerial), .spreadDown(spreadDown),
    .spreadOn(spreadOn), .outputsOff(outputsOff)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic mStart();
    mLow = 1'b0; waitq();
    sclLvl = 1'b1; waitq();
    mLow = 1'b1; waitq();
    sclLvl = 1'b0; waitq();
  endtask

  task automatic mStop();
    mLow = 1'b1; waitq();
    sclLvl = 1'b1; waitq();
    mLow = 1'b0; waitq();
  endtask

  task automatic mSend(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mLow = ~b[i]; waitq();
      sclLvl = 1'b1; waitq();
      sclLvl = 1'b0;
    end
    mLow = 1'b0; waitq();
    sclLvl = 1'b1; waitq();
    acked = ~sdaLine;
    sclLvl = 1'b0;
  endtask

  task automatic mRecv(input logic giveAck, output logic [7:0] b);
    mLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitq();
      sclLvl = 1'b1; waitq();
      b[i] = sdaLine;
      sclLvl = 1'b0;
    end
    mLow = giveAck; waitq();
    sclLvl = 1'b1; waitq();
    sclLvl = 1'b0;
    mLow = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic allAck;
    logic [7:0] rb;
    logic [47:0] snap;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset contents and released line
    chk("R1 reset registers", regFile, 48'hFFFF_FFFF_FF00);
    chk("R1 line released", sdaDriveLow, 1'b0);

    // R11 table: write one byte into register 0, check decoded pins
    for (int v = 0; v < NV; v++) begin
      mStart();
      mSend(WA, a); mSend(8'h00, a); mSend(8'h01, a); mSend(VEC[v], a);
      mStop();
      chk("R11 field pins", {freqCode, freqBySerial, spreadDown, spreadOn, outputsOff},
          {57'd0, VEC[v][6:0]});
      chk("R3 register 0 value", regFile[7:0], VEC[v]);
    end

    // R2 R3 R4 R6 full write with two bytes beyond the bank
    allAck = 1'b1;
    mStart();
    mSend(WA, a); chk("R2 write address acked", a, 1'b1);
    mSend(8'h55, a); allAck &= a;
    mSend(8'h06, a); allAck &= a;
    for (int k = 1; k <= 8; k++) begin
      mSend(8'(k * 8'h11), a); allAck &= a;
    end
    mStop();
    chk("R4 all bytes acked", allAck, 1'b1);
    chk("R3 R6 register contents", regFile, 48'h6655_4433_2211);

    // R5 foreign address: no acknowledge, no change
    mStart();
    mSend(8'hA0, a); chk("R5 foreign address not acked", a, 1'b0);
    mSend(8'h00, a); mSend(8'h00, a); mSend(8'h99, a);
    mStop();
    chk("R5 registers unchanged", regFile, 48'h6655_4433_2211);

    // R10 write with header only
    mStart();
    mSend(WA, a); mSend(8'hAA, a); mSend(8'h03, a);
    mStop();
    chk("R10 empty write no change", regFile, 48'h6655_4433_2211);
    chk("R12 released after stop", sdaDriveLow, 1'b0);

    // R7 R8 full read past the end
    mStart();
    mSend(RA, a); chk("R7 read address acked", a, 1'b1);
    mRecv(1'b1, rb); chk("R7 count byte", rb, 8'h06);
    for (int k = 0; k < 6; k++) begin
      mRecv(1'b1, rb); chk("R7 register byte", rb, 8'(8'h11 * (k + 1)));
    end
    mRecv(1'b0, rb); chk("R8 past end reads FF", rb, 8'hFF);
    mStop();

    // R9 master NACK ends read
    mStart();
    mSend(RA, a);
    mRecv(1'b1, rb);
    mRecv(1'b1, rb); chk("R7 first register", rb, 8'h11);
    mRecv(1'b0, rb); chk("R7 second register", rb, 8'h22);
    mRecv(1'b0, rb); chk("R9 released after NACK", rb, 8'hFF);
    mStop();

    // R13 repeated start after a partial write
    mStart();
    mSend(WA, a); mSend(8'h00, a); mSend(8'h00, a); mSend(8'h5A, a);
    mStart();
    mSend(RA, a); chk("R13 read after repeated start acked", a, 1'b1);
    mRecv(1'b1, rb); chk("R13 count byte", rb, 8'h06);
    mRecv(1'b0, rb); chk("R13 register 0 read", rb, 8'h5A);
    mStop();
    snap = regFile;
    chk("R13 other registers kept", snap[47:8], 40'h6655_4433_22);
    chk("R12 idle line", sdaDriveLow, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule